// File: doc/BRIEF.md
# Programmable Event Routing Fabric

This block moves single-cycle event pulses from a set of publishers to a set of subscriber ports. Each publisher owns a 4-bit channel selector. A selector of zero keeps that publisher off every channel. Selectors 1 to 11 pick point-to-point channels, and selectors 12 to 15 pick splitter channels. Each subscriber port owns its own 4-bit selector that names the channel it listens to. A subscriber output can drive a peripheral trigger input, a DMA trigger input or a CPU event input. The fabric treats all three the same way.

Beside the programmable channels, every publisher has a fixed interrupt line that reaches the CPU without any configuration. A small register port holds all the selectors and a sticky collision flag. Software writes the selectors through this port and reads them back through it. Every output comes from a register, so an event reaches its subscriber exactly one clock after the publisher pulses.

Top module: `evr_fabric`

## Requirements
- R1: After a synchronous reset every selector reads 0, the collision flag reads 0, and `sub_evt_o`, `cpu_irq_o` and `rd_data_o` are 0. With all selectors at 0, no publisher pulse reaches any subscriber.
- R2: A publisher whose selector is 0 places nothing on any channel.
- R3: A subscriber port whose selector is 0 never pulses.
- R4: Selectors 1 to 11 name point-to-point channels. A pulse on such a channel reaches only the lowest-indexed subscriber port that selects it.
- R5: Selectors 12 to 15 name splitter channels. A pulse on such a channel reaches the two lowest-indexed subscriber ports that select it, and no third port.
- R6: A publisher pulse in cycle k appears on the chosen subscriber outputs in cycle k+1 only. A subscriber output pulses only in the cycle after some publisher pulsed.
- R7: `cpu_irq_o[p]` equals `pub_irq_i[p]` delayed by one clock, whatever the selectors hold. It reads 0 while reset is held.
- R8: Pulses from several publishers on the same channel in one cycle merge into one channel pulse and set the sticky collision flag. A single publisher never sets the flag.
- R9: Writing a value whose bit 0 is 1 to the status address clears the collision flag. Writing 0 there leaves the flag unchanged. A collision in the same cycle as the clearing write keeps the flag at 1.
- R10: A selector write becomes active at the clock edge that performs it. A pulse presented in the same cycle as the write is routed under the old selectors.
- R11: Register map: address p (0 to N_PUB-1) is publisher p's selector. Address N_PUB+s is subscriber s's selector. Address N_PUB+N_SUB is the status register, with the collision flag in bit 0. `rd_data_o` returns the register at `rd_addr_i` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pub_evt_i | input | N_PUB | One-cycle event pulse from each publisher |
| pub_irq_i | input | N_PUB | Interrupt request from each publisher |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | 4 | Register write data |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | 4 | Registered read data |
| sub_evt_o | output | N_SUB | Registered event pulse to each subscriber port |
| cpu_irq_o | output | N_PUB | Registered static interrupt lines to the CPU |

## Verification
The bench sets up two ports on one point-to-point channel and three ports on one splitter channel. A design that ignores subscriber order would pulse every matching port, and this setup catches it. A selector write is issued in the same cycle as a pulse. A fabric that used the new selectors too early would send that pulse to the wrong port. Two publishers share a channel while the collision flag is cleared by a write of 1, by a write of 0, and by a write of 1 in the collision cycle itself. A design that lost the set-over-clear order, or cleared on any write, would read back the wrong flag. The bench also holds the interrupt inputs high during reset and with no routing set up. This exposes an interrupt path that is gated by the selectors or escapes reset.

// File: rtl/evr_pkg.sv
package evr_pkg;
  // Width of every channel selector; channel 0 means "not connected".
  localparam int CH_W = 4;
  localparam int N_CH = 1 << CH_W;
  // First selector value that names a two-way splitter channel.
  localparam int SPLIT_FIRST_DEF = 12;
  typedef logic [CH_W-1:0] chan_id_t;
endpackage

// File: rtl/evr_cfg_regs.sv
module evr_cfg_regs
  import evr_pkg::*;
#(
  parameter int N_PUB  = 4,
  parameter int N_SUB  = 6,
  parameter int ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  chan_id_t                wr_data_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output chan_id_t                rd_data_o,
  input  logic                    coll_set_i,
  output logic [N_PUB*CH_W-1:0]   pub_ch_o,
  output logic [N_SUB*CH_W-1:0]   sub_ch_o,
  output logic                    coll_q_o,
  output logic                    stat_clr_o
);
  localparam int STAT_ADDR = N_PUB + N_SUB;

  // Publisher selectors, one register each.
  for (genvar g = 0; g < N_PUB; g++) begin : g_pub
    always_ff @(posedge clk) begin
      if (rst)
        pub_ch_o[g*CH_W +: CH_W] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(g))
        pub_ch_o[g*CH_W +: CH_W] <= wr_data_i;
    end
  end

  // Subscriber selectors follow the publisher block in the address space.
  for (genvar g = 0; g < N_SUB; g++) begin : g_sub
    always_ff @(posedge clk) begin
      if (rst)
        sub_ch_o[g*CH_W +: CH_W] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(N_PUB + g))
        sub_ch_o[g*CH_W +: CH_W] <= wr_data_i;
    end
  end

  // Sticky collision flag: a new collision wins over a clearing write.
  assign stat_clr_o = wr_en_i && (wr_addr_i == ADDR_W'(STAT_ADDR)) && wr_data_i[0];

  always_ff @(posedge clk) begin
    if (rst)             coll_q_o <= 1'b0;
    else if (coll_set_i) coll_q_o <= 1'b1;
    else if (stat_clr_o) coll_q_o <= 1'b0;
  end

  // Registered read mux.
  chan_id_t rd_next;
  always_comb begin
    rd_next = '0;
    for (int p = 0; p < N_PUB; p++)
      if (rd_addr_i == ADDR_W'(p)) rd_next = pub_ch_o[p*CH_W +: CH_W];
    for (int s = 0; s < N_SUB; s++)
      if (rd_addr_i == ADDR_W'(N_PUB + s)) rd_next = sub_ch_o[s*CH_W +: CH_W];
    if (rd_addr_i == ADDR_W'(STAT_ADDR)) rd_next = {{(CH_W-1){1'b0}}, coll_q_o};
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else     rd_data_o <= rd_next;
  end
endmodule

// File: rtl/evr_chan_merge.sv
module evr_chan_merge
  import evr_pkg::*;
#(
  parameter int N_PUB = 4
) (
  input  logic [N_PUB-1:0]      pub_evt_i,
  input  logic [N_PUB*CH_W-1:0] pub_ch_i,
  output logic [N_CH-1:0]       chan_evt_o,
  output logic                  coll_o
);
  logic [N_CH-1:0] dup;
  chan_id_t        id;

  // OR every active publisher onto its channel; flag any second driver.
  always_comb begin
    chan_evt_o = '0;
    dup        = '0;
    id         = '0;
    for (int p = 0; p < N_PUB; p++) begin
      id = pub_ch_i[p*CH_W +: CH_W];
      if (pub_evt_i[p] && id != '0) begin
        if (chan_evt_o[id]) dup[id] = 1'b1;
        chan_evt_o[id] = 1'b1;
      end
    end
    coll_o = |dup;
  end
endmodule

// File: rtl/evr_sub_select.sv
module evr_sub_select
  import evr_pkg::*;
#(
  parameter int N_SUB       = 6,
  parameter int SPLIT_FIRST = SPLIT_FIRST_DEF
) (
  input  logic [N_CH-1:0]       chan_evt_i,
  input  logic [N_SUB*CH_W-1:0] sub_ch_i,
  output logic [N_SUB-1:0]      sub_hit_o
);
  localparam int RK_W = $clog2(N_SUB + 1) + 1;

  // Each port counts lower-indexed ports on its channel and compares the
  // count with the channel's fan-out (1 or 2).
  for (genvar s = 0; s < N_SUB; s++) begin : g_port
    chan_id_t        my_ch;
    logic [RK_W-1:0] rank;
    logic [RK_W-1:0] limit;

    always_comb begin
      my_ch = sub_ch_i[s*CH_W +: CH_W];
      rank  = '0;
      for (int j = 0; j < s; j++)
        if (sub_ch_i[j*CH_W +: CH_W] == my_ch) rank = rank + RK_W'(1);
      if (my_ch == '0)                       limit = '0;
      else if (my_ch >= CH_W'(SPLIT_FIRST))  limit = RK_W'(2);
      else                                   limit = RK_W'(1);
      sub_hit_o[s] = chan_evt_i[my_ch] && (rank < limit);
    end
  end
endmodule

// File: rtl/evr_fabric.sv
module evr_fabric
  import evr_pkg::*;
#(
  parameter int N_PUB       = 4,
  parameter int N_SUB       = 6,
  parameter int ADDR_W      = 4,
  parameter int SPLIT_FIRST = SPLIT_FIRST_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PUB-1:0]  pub_evt_i,
  input  logic [N_PUB-1:0]  pub_irq_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CH_W-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CH_W-1:0]   rd_data_o,
  output logic [N_SUB-1:0]  sub_evt_o,
  output logic [N_PUB-1:0]  cpu_irq_o
);
  logic [N_PUB*CH_W-1:0] pub_ch_w;
  logic [N_SUB*CH_W-1:0] sub_ch_w;
  logic [N_CH-1:0]       chan_evt_w;
  logic [N_SUB-1:0]      sub_hit_w;
  logic                  coll_det_w;
  logic                  coll_q_w;
  logic                  stat_clr_w;

  evr_cfg_regs #(.N_PUB(N_PUB), .N_SUB(N_SUB), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o),
    .coll_set_i (coll_det_w),
    .pub_ch_o   (pub_ch_w),
    .sub_ch_o   (sub_ch_w),
    .coll_q_o   (coll_q_w),
    .stat_clr_o (stat_clr_w)
  );

  evr_chan_merge #(.N_PUB(N_PUB)) u_merge (
    .pub_evt_i  (pub_evt_i),
    .pub_ch_i   (pub_ch_w),
    .chan_evt_o (chan_evt_w),
    .coll_o     (coll_det_w)
  );

  evr_sub_select #(.N_SUB(N_SUB), .SPLIT_FIRST(SPLIT_FIRST)) u_select (
    .chan_evt_i (chan_evt_w),
    .sub_ch_i   (sub_ch_w),
    .sub_hit_o  (sub_hit_w)
  );

  // Single output stage for routed events and the fixed interrupt lines.
  always_ff @(posedge clk) begin
    if (rst) begin
      sub_evt_o <= '0;
      cpu_irq_o <= '0;
    end else begin
      sub_evt_o <= sub_hit_w;
      cpu_irq_o <= pub_irq_i;
    end
  end
endmodule

// File: rtl/evr_fabric_chk.sv
module evr_fabric_chk
  import evr_pkg::*;
#(
  parameter int N_PUB = 4,
  parameter int N_SUB = 6
) (
  input logic                  clk,
  input logic                  rst,
  input logic [N_PUB-1:0]      pub_evt_i,
  input logic [N_PUB-1:0]      pub_irq_i,
  input logic [N_SUB-1:0]      sub_evt_o,
  input logic [N_PUB-1:0]      cpu_irq_o,
  input logic [N_SUB*CH_W-1:0] sub_ch,
  input logic                  coll_q,
  input logic                  coll_det,
  input logic                  stat_clr
);
  p_irq_follow_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cpu_irq_o == $past(pub_irq_i));

  p_no_source_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (|sub_evt_o)) |-> (|$past(pub_evt_i)));

  p_fanout_bound_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $countones(sub_evt_o) <= 2 * $countones($past(pub_evt_i)));

  p_coll_sets_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(coll_det)) |-> coll_q);

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(coll_q) && !$past(stat_clr)) |-> coll_q);

  for (genvar s = 0; s < N_SUB; s++) begin : g_quiet
    p_quiet_sub_r3: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(sub_ch[s*CH_W +: CH_W]) == '0) |-> !sub_evt_o[s]);
  end
endmodule

bind evr_fabric evr_fabric_chk #(.N_PUB(N_PUB), .N_SUB(N_SUB)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pub_evt_i (pub_evt_i),
  .pub_irq_i (pub_irq_i),
  .sub_evt_o (sub_evt_o),
  .cpu_irq_o (cpu_irq_o),
  .sub_ch    (sub_ch_w),
  .coll_q    (coll_q_w),
  .coll_det  (coll_det_w),
  .stat_clr  (stat_clr_w)
);

// File: tb/evr_fabric_test.sv
module evr_fabric_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int NS = 6;
  localparam int AW = 4;
  localparam int STAT = NP + NS;

  // {irq[3:0], pub[3:0], expected sub[5:0]} under the table configuration:
  // pub0->3, pub1->12, pub2->5, pub3->0; sub0,sub1->3; sub2..4->12; sub5->5.
  localparam logic [13:0] VEC [8] = '{
    {4'b0000, 4'b0001, 6'b000001},
    {4'b0101, 4'b0010, 6'b001100},
    {4'b1010, 4'b0100, 6'b100000},
    {4'b1111, 4'b1000, 6'b000000},
    {4'b0011, 4'b0111, 6'b101101},
    {4'b1100, 4'b1111, 6'b101101},
    {4'b0000, 4'b0000, 6'b000000},
    {4'b1001, 4'b0011, 6'b001101}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0] pub_evt = '0;
  logic [NP-1:0] pub_irq = '0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [3:0] rd_data;
  logic [NS-1:0] sub_evt;
  logic [NP-1:0] cpu_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evr_fabric uut (
    .clk(clk), .rst(rst), .pub_evt_i(pub_evt), .pub_irq_i(pub_irq),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .sub_evt_o(sub_evt),
    .cpu_irq_o(cpu_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(addr); wr_data = 4'(data);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [3:0] val);
    @(negedge clk);
    rd_addr = AW'(addr);
    @(posedge clk); #1;
    val = rd_data;
  endtask

  task automatic fire(input logic [NP-1:0] p);
    @(negedge clk);
    pub_evt = p;
    @(posedge clk); #1;
    pub_evt = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0] v;
    pub_irq = 4'b1111;
    repeat (3) @(posedge clk);
    #1;
    check("R7 irq held low in reset", 32'(cpu_irq), 32'h0);
    check("R1 sub reset", 32'(sub_evt), 32'h0);
    @(negedge clk);
    rst = 1'b0;
    pub_irq = '0;
    @(posedge clk); #1;

    rd(0, v);    check("R1 pub0 selector reset", 32'(v), 32'h0);
    rd(NP, v);   check("R1 sub0 selector reset", 32'(v), 32'h0);
    rd(STAT, v); check("R1 collision flag reset", 32'(v), 32'h0);

    // Nothing configured: no routing, interrupts still pass.
    @(negedge clk);
    pub_evt = 4'b1111; pub_irq = 4'b1010;
    @(posedge clk); #1;
    check("R1 unconfigured no routing", 32'(sub_evt), 32'h0);
    check("R7 irq without config", 32'(cpu_irq), 32'hA);
    pub_evt = '0; pub_irq = '0;

    // Table configuration.
    wr(0, 3); wr(1, 12); wr(2, 5); wr(3, 0);
    wr(NP+0, 3); wr(NP+1, 3); wr(NP+2, 12); wr(NP+3, 12); wr(NP+4, 12); wr(NP+5, 5);
    rd(1, v);    check("R11 pub1 readback", 32'(v), 32'hC);
    rd(NP+5, v); check("R11 sub5 readback", 32'(v), 32'h5);

    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      pub_irq = VEC[i][13:10];
      pub_evt = VEC[i][9:6];
      @(posedge clk); #1;
      check("R2 R4 R5 table routing", 32'(sub_evt), 32'(VEC[i][5:0]));
      check("R7 table irq", 32'(cpu_irq), 32'(VEC[i][13:10]));
      pub_evt = '0;
    end
    pub_irq = '0;

    // R6: output lasts one cycle only.
    fire(4'b0010);
    check("R6 one-cycle latency", 32'(sub_evt), 32'h0C);
    @(posedge clk); #1;
    check("R6 pulse ends", 32'(sub_evt), 32'h0);

    // R10: write in the same cycle as a pulse uses the old selectors.
    @(negedge clk);
    pub_evt = 4'b0001; wr_en = 1'b1; wr_addr = AW'(NP); wr_data = 4'd0;
    @(posedge clk); #1;
    pub_evt = '0; wr_en = 1'b0;
    check("R10 old routing on write cycle", 32'(sub_evt), 32'h01);
    fire(4'b0001);
    check("R10 R3 R4 new routing next", 32'(sub_evt), 32'h02);

    // R3: disconnect sub5 and fire its channel.
    wr(NP+5, 0);
    fire(4'b0100);
    check("R3 disconnected port silent", 32'(sub_evt), 32'h0);

    // R8: two publishers on channel 3.
    wr(2, 3);
    fire(4'b0101);
    check("R8 merged pulse", 32'(sub_evt), 32'h02);
    rd(STAT, v); check("R8 collision flag set", 32'(v), 32'h1);
    wr(STAT, 0);
    rd(STAT, v); check("R9 write 0 keeps flag", 32'(v), 32'h1);
    wr(STAT, 1);
    rd(STAT, v); check("R9 write 1 clears flag", 32'(v), 32'h0);
    fire(4'b0001);
    rd(STAT, v); check("R8 single publisher no flag", 32'(v), 32'h0);

    // R9: collision in the cycle of a clearing write.
    @(negedge clk);
    pub_evt = 4'b0101; wr_en = 1'b1; wr_addr = AW'(STAT); wr_data = 4'd1;
    @(posedge clk); #1;
    pub_evt = '0; wr_en = 1'b0;
    rd(STAT, v); check("R9 set beats clear", 32'(v), 32'h1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule